// File: doc/BRIEF.md
# Joinable Transmit/Receive Word FIFO Pair

This block sits between a bus or DMA side and an I/O state machine. It holds two word queues. The transmit queue takes words from the bus and hands them to the state machine. The receive queue takes words from the state machine and hands them back to the bus. Every port uses a valid/ready handshake. A transfer happens on a rising clock edge when both valid and ready are high. Each queue also reports its fill level and its full and empty flags.

In normal operation each queue owns four entries of the shared storage. When the join input is set, all eight entries serve one queue, and the direction input selects which one. The other queue is then shut off. Any change to the join or direction inputs empties both queues.

Top module: `io_fifo_pair`

## Requirements
- R1: In split mode (`join_en`=0) each queue holds at most 4 words. At a level of 4 it raises its full flag, and its write ready drops unless a read happens in the same cycle.
- R2: Each queue returns words in the order they were written, with no loss or duplication. Read valid is low whenever the level is 0.
- R3: While a queue is not full, its write ready is high. A write is then accepted on every clock, so back-to-back writes raise the level by one per cycle.
- R4: A write and a read in the same cycle on a full queue are both accepted. The level stays the same and the read returns the oldest word.
- R5: With `join_en`=1 and `join_dir`=0, the transmit queue holds 8 words. It raises full at a level of 8 and returns all 8 words in order.
- R6: With `join_en`=1 and `join_dir`=1, the receive queue holds 8 words. It raises full at a level of 8 and returns all 8 words in order.
- R7: In joined mode the unselected queue keeps write ready low and full high, keeps read valid low and empty high, and reports level 0. A write offered to it is ignored.
- R8: In the cycle where {`join_en`,`join_dir`} differs from the value it held on the previous clock, every write ready and read valid is low. After that edge, both levels are 0.
- R9: After reset, both queues are empty with level 0, full is low, the write readies are high and the read valids are low.
- R10: A word written on a clock edge shows up on the read side of its queue right after that edge.
- R11: The level output equals the number of words stored. Empty is high exactly when the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| join_en | input | 1 | 1 joins all storage into one 8-deep queue |
| join_dir | input | 1 | Queue that gets the joined storage: 0 transmit, 1 receive |
| bus_tx_data | input | 32 | Transmit word from the bus |
| bus_tx_valid | input | 1 | Bus offers a transmit word |
| bus_tx_ready | output | 1 | Transmit queue accepts a word |
| sm_tx_data | output | 32 | Oldest transmit word for the state machine |
| sm_tx_valid | output | 1 | Transmit word available |
| sm_tx_ready | input | 1 | State machine takes the transmit word |
| sm_rx_data | input | 32 | Receive word from the state machine |
| sm_rx_valid | input | 1 | State machine offers a receive word |
| sm_rx_ready | output | 1 | Receive queue accepts a word |
| bus_rx_data | output | 32 | Oldest receive word for the bus |
| bus_rx_valid | output | 1 | Receive word available |
| bus_rx_ready | input | 1 | Bus takes the receive word |
| tx_level | output | 4 | Words held in the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_level | output | 4 | Words held in the receive queue |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |

## Verification
The assertions check several rules on every cycle:
- the level never goes above the capacity of the current mode;
- no read is taken from an empty queue;
- a write that is offered while the queue has room is always accepted;
- a write plus read on a full queue leaves the level unchanged;
- a configuration change clears both levels;
- the queue shut off in joined mode stays idle.

Only the bench scenarios can show that the data comes out in order and with the right values. They also cover the one-cycle latency from write to read, the exact capacity of 4 or 8 in each mode, and the loss of stored words when the configuration changes.

// File: rtl/io_fifo_pair.sv
module io_fifo_pair #(
  parameter int W           = 32,
  parameter int SPLIT_DEPTH = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 join_en,
  input  logic                                 join_dir,
  input  logic [W-1:0]                         bus_tx_data,
  input  logic                                 bus_tx_valid,
  output logic                                 bus_tx_ready,
  output logic [W-1:0]                         sm_tx_data,
  output logic                                 sm_tx_valid,
  input  logic                                 sm_tx_ready,
  input  logic [W-1:0]                         sm_rx_data,
  input  logic                                 sm_rx_valid,
  output logic                                 sm_rx_ready,
  output logic [W-1:0]                         bus_rx_data,
  output logic                                 bus_rx_valid,
  input  logic                                 bus_rx_ready,
  output logic [$clog2(2*SPLIT_DEPTH+1)-1:0]   tx_level,
  output logic                                 tx_full,
  output logic                                 tx_empty,
  output logic [$clog2(2*SPLIT_DEPTH+1)-1:0]   rx_level,
  output logic                                 rx_full,
  output logic                                 rx_empty
);
  localparam int JOIN_DEPTH = 2 * SPLIT_DEPTH;
  localparam int AW         = $clog2(JOIN_DEPTH);
  localparam int LW         = $clog2(JOIN_DEPTH + 1);

  logic [W-1:0] mem [JOIN_DEPTH];
  logic [1:0]   cfg_q;
  logic         flush;

  logic [1:0]          wvalid, wready, wfire, rvalid, rready, rfire, full, empty;
  logic [W-1:0]        wdat [2];
  logic [W-1:0]        rdat [2];
  logic [1:0][AW-1:0]  waddr, raddr;
  logic [1:0][LW-1:0]  lvl;

  // Any change of the join configuration flushes both queues for one cycle.
  assign flush = ({join_en, join_dir} != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= 2'b00;
    else        cfg_q <= {join_en, join_dir};
  end

  // Index 0 is the transmit queue, index 1 the receive queue.
  assign wdat[0] = bus_tx_data;
  assign wdat[1] = sm_rx_data;
  assign wvalid  = {sm_rx_valid, bus_tx_valid};
  assign rready  = {bus_rx_ready, sm_tx_ready};

  assign bus_tx_ready = wready[0];
  assign sm_rx_ready  = wready[1];
  assign sm_tx_valid  = rvalid[0];
  assign bus_rx_valid = rvalid[1];
  assign sm_tx_data   = rdat[0];
  assign bus_rx_data  = rdat[1];
  assign tx_level     = lvl[0];
  assign rx_level     = lvl[1];
  assign tx_full      = full[0];
  assign rx_full      = full[1];
  assign tx_empty     = empty[0];
  assign rx_empty     = empty[1];

  always_ff @(posedge clk) begin
    for (int d = 0; d < 2; d++)
      if (wfire[d]) mem[waddr[d]] <= wdat[d];
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam bit SIDE = (d == 1);

    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] cnt, depth;

    assign depth = !join_en           ? LW'(SPLIT_DEPTH) :
                   (join_dir == SIDE) ? LW'(JOIN_DEPTH)  : '0;

    assign full[d]   = (cnt >= depth);
    assign empty[d]  = (cnt == '0);
    assign rvalid[d] = !flush && !empty[d];
    assign rfire[d]  = rvalid[d] && rready[d];
    assign wready[d] = !flush && (!full[d] || rfire[d]);
    assign wfire[d]  = wvalid[d] && wready[d];
    assign lvl[d]    = cnt;

    assign waddr[d] = join_en ? wptr : {SIDE, wptr[AW-2:0]};
    assign raddr[d] = join_en ? rptr : {SIDE, rptr[AW-2:0]};
    assign rdat[d]  = mem[raddr[d]];

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
      end else begin
        wptr <= wptr + AW'(wfire[d]);
        rptr <= rptr + AW'(rfire[d]);
        cnt  <= cnt + LW'(wfire[d]) - LW'(rfire[d]);
      end
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> (cnt <= depth));

    assert_no_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rfire[d] |-> (cnt != '0));

    assert_sustain_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && cnt < depth) |-> wready[d]);

    assert_full_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && cnt == depth && depth != '0 && wfire[d] && rfire[d]) |=> (cnt == $past(cnt)));

    assert_unused_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (join_en && join_dir != SIDE) |-> (!wready[d] && !rvalid[d]));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0));
  end

endmodule

// File: tb/test_io_fifo_pair.sv
module test_io_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        join_en = 1'b0, join_dir = 1'b0;
  logic [31:0] bus_tx_data = '0, sm_rx_data = '0;
  logic        bus_tx_valid = 1'b0, sm_rx_valid = 1'b0;
  logic        sm_tx_ready = 1'b0, bus_rx_ready = 1'b0;
  logic        bus_tx_ready, sm_tx_valid, sm_rx_ready, bus_rx_valid;
  logic [31:0] sm_tx_data, bus_rx_data;
  logic [3:0]  tx_level, rx_level;
  logic        tx_full, tx_empty, rx_full, rx_empty;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  io_fifo_pair i_io_fifo_pair (
    .clk(clk), .rst_n(rst_n), .join_en(join_en), .join_dir(join_dir),
    .bus_tx_data(bus_tx_data), .bus_tx_valid(bus_tx_valid), .bus_tx_ready(bus_tx_ready),
    .sm_tx_data(sm_tx_data), .sm_tx_valid(sm_tx_valid), .sm_tx_ready(sm_tx_ready),
    .sm_rx_data(sm_rx_data), .sm_rx_valid(sm_rx_valid), .sm_rx_ready(sm_rx_ready),
    .bus_rx_data(bus_rx_data), .bus_rx_valid(bus_rx_valid), .bus_rx_ready(bus_rx_ready),
    .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_w(int d, logic v, logic [31:0] x);
    if (d == 0) begin bus_tx_valid = v; bus_tx_data = x; end
    else        begin sm_rx_valid  = v; sm_rx_data  = x; end
  endtask

  task automatic drive_r(int d, logic r);
    if (d == 0) sm_tx_ready = r; else bus_rx_ready = r;
  endtask

  function automatic logic wrdy(int d);      return d == 0 ? bus_tx_ready : sm_rx_ready;  endfunction
  function automatic logic rval(int d);      return d == 0 ? sm_tx_valid  : bus_rx_valid; endfunction
  function automatic logic [31:0] rdat(int d); return d == 0 ? sm_tx_data : bus_rx_data;  endfunction
  function automatic logic [3:0] lvl(int d); return d == 0 ? tx_level : rx_level;         endfunction
  function automatic logic isfull(int d);    return d == 0 ? tx_full  : rx_full;          endfunction
  function automatic logic isempty(int d);   return d == 0 ? tx_empty : rx_empty;         endfunction

  task automatic push(int d, logic [31:0] x);
    @(negedge clk); drive_w(d, 1'b1, x);
    @(negedge clk); drive_w(d, 1'b0, '0);
  endtask

  task automatic t_reset;
    #1;
    for (int d = 0; d < 2; d++) begin
      check("R9 level", lvl(d), 0);
      check("R9 empty", isempty(d), 1);
      check("R9 full", isfull(d), 0);
      check("R9 wready", wrdy(d), 1);
      check("R9 rvalid", rval(d), 0);
    end
  endtask

  task automatic t_split_fill_drain(int d, logic [31:0] base);
    for (int k = 0; k <= 4; k++) begin
      @(negedge clk); drive_w(d, 1'b1, base + k); #1;
      check("R3 level per cycle", lvl(d), k);
      check("R1 wready", wrdy(d), k < 4);
      check("R1 full", isfull(d), k == 4);
      check("R11 empty flag", isempty(d), k == 0);
    end
    @(negedge clk); drive_w(d, 1'b0, '0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); drive_r(d, 1'b1); #1;
      check("R2 valid", rval(d), 1);
      check("R2 order", rdat(d), base + k);
    end
    @(negedge clk); drive_r(d, 1'b0); #1;
    check("R2 drained empty", isempty(d), 1);
    check("R11 level after drain", lvl(d), 0);
    check("R2 no valid when empty", rval(d), 0);
  endtask

  task automatic t_latency;
    @(negedge clk); drive_w(1, 1'b1, 32'hC0DE_0001); #1;
    check("R10 not visible before edge", bus_rx_valid, 0);
    @(negedge clk); drive_w(1, 1'b0, '0); #1;
    check("R10 visible after edge", bus_rx_valid, 1);
    check("R10 data", bus_rx_data, 32'hC0DE_0001);
    @(negedge clk); drive_r(1, 1'b1);
    @(negedge clk); drive_r(1, 1'b0); #1;
    check("R11 level back to 0", rx_level, 0);
  endtask

  task automatic t_full_rw;
    for (int k = 0; k < 4; k++) push(0, 32'hB000_0000 + k);
    @(negedge clk); drive_w(0, 1'b1, 32'hB000_0004); drive_r(0, 1'b1); #1;
    check("R4 full flag", tx_full, 1);
    check("R4 ready with read", bus_tx_ready, 1);
    check("R4 oldest out", sm_tx_data, 32'hB000_0000);
    @(negedge clk); drive_w(0, 1'b0, '0); drive_r(0, 1'b0); #1;
    check("R4 level kept", tx_level, 4);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); drive_r(0, 1'b1); #1;
      check("R4 order after pass", sm_tx_data, 32'hB000_0000 + k);
    end
    @(negedge clk); drive_r(0, 1'b0);
  endtask

  task automatic t_join(int dir);
    int u = 1 - dir;
    string rq = (dir == 0) ? "R5" : "R6";
    push(0, 32'h1111_0000); push(0, 32'h1111_0001); push(1, 32'h2222_0000);
    @(negedge clk); join_en = 1'b1; join_dir = dir[0]; drive_w(dir, 1'b1, 32'hDEAD_0000); #1;
    check("R8 write blocked in change cycle", wrdy(dir), 0);
    check("R8 tx read blocked in change cycle", sm_tx_valid, 0);
    check("R8 rx read blocked in change cycle", bus_rx_valid, 0);
    @(negedge clk); drive_w(dir, 1'b0, '0); #1;
    check("R8 tx flushed", tx_level, 0);
    check("R8 rx flushed", rx_level, 0);
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk); drive_w(dir, 1'b1, 32'h5A00_0000 + k); #1;
      check({rq, " level"}, lvl(dir), k);
      check({rq, " wready"}, wrdy(dir), k < 8);
      check({rq, " full"}, isfull(dir), k == 8);
    end
    @(negedge clk); drive_w(dir, 1'b0, '0);
    drive_w(u, 1'b1, 32'hBAD0_BAD0); drive_r(u, 1'b1); #1;
    check("R7 unused wready", wrdy(u), 0);
    check("R7 unused rvalid", rval(u), 0);
    check("R7 unused full", isfull(u), 1);
    check("R7 unused empty", isempty(u), 1);
    @(negedge clk); drive_w(u, 1'b0, '0); drive_r(u, 1'b0); #1;
    check("R7 unused level", lvl(u), 0);
    check("R7 active level untouched", lvl(dir), 8);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); drive_r(dir, 1'b1); #1;
      check({rq, " order"}, rdat(dir), 32'h5A00_0000 + k);
    end
    @(negedge clk); drive_r(dir, 1'b0); #1;
    check({rq, " drained"}, isempty(dir), 1);
    push(dir, 32'h7777_0000);
    @(negedge clk); join_en = 1'b0; join_dir = 1'b0;
    @(negedge clk); #1;
    check("R8 flush on leaving join", lvl(dir), 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_fill_drain(0, 32'hA000_0000);
    t_split_fill_drain(1, 32'hE000_0000);
    t_latency();
    t_full_rw();
    t_join(0);
    t_join(1);
    finish_run();
  end
endmodule